// File: doc/BRIEF.md
# Windowed Service Watchdog with Start-up Supervision

This block supervises a host processor through a single service register. The host writes one word that holds an operating-mode code, a period code and a prescaler setting. That write is both the mode change and the watchdog service. Because of this, the host cannot change modes without also serving the watchdog. Time is measured in ticks of an enable input, so the block runs from whatever slow time base the chip provides.

After power-on, and after every reset request the block makes itself, it runs a start-up phase with a fixed timeout. If the host misses that timeout once, the block asks for a reset and starts the phase again. If it misses it a second time in a row, the block enters a fail-safe state that only power-on reset can leave. Once the host selects the run mode, every service must land in the second half of the programmed period. A service that is too early, a missing service, or an illegal code requests a one-cycle reset and sets a sticky error bit. Software clears that bit by writing a one to it.

Top module: `winwdg`

## Requirements
- R1: While `por_n` is low, and on the first cycle after it rises, the outputs are: `rst_req`=0, `fail_safe`=0, `startup`=1, `err_flags`=0, `mode`=0. All outputs are registered.
- R2: `wr_data` is split into mode in bits [2:0], period code in bits [6:3] and prescaler in bits [8:7]. In the start-up phase, a legal write is accepted at any tick count. It loads the three fields and ends start-up. Mode 1 is the run (window) mode.
- R3: In start-up, if INIT_TICKS ticks pass with no legal write, the block gives a one-cycle `rst_req` pulse and restarts the start-up phase. A tick in the same cycle as a legal write does not count toward this limit.
- R4: If start-up expires twice in a row with no accepted write between the two, `fail_safe` rises, `startup` drops and `mode` reads 0. After that, writes are ignored and `rst_req` stays low until `por_n` goes low.
- R5: The period length in ticks is the base for the code times 2 to the power of the prescaler. The bases for codes 0 to 9 are 8, 16, 32, 40, 48, 64, 128, 256, 512 and 1024.
- R6: In run mode, a legal write is accepted when the count of ticks since the last restart (before this cycle's tick) is at least half the period. An accepted write restarts the count and loads the new fields.
- R7: In run mode, a legal write below half the period is a too-early fault. It raises `rst_req` for one cycle, sets `err_flags[0]`, returns the block to start-up and sets `mode` to 0.
- R8: In run mode, if the tick that would complete the period arrives with no write, that is a late fault. It raises `rst_req`, sets `err_flags[1]`, returns the block to start-up and sets `mode` to 0.
- R9: Mode codes 6 and 7, and period codes 10 to 15, are illegal. Such a write is not loaded and sets `err_flags[2]`. In run mode it also raises `rst_req` and returns to start-up. In start-up or in other modes the timer keeps counting.
- R10: In legal modes other than run, a legal write is accepted at any count. Only the timeout applies, and it gives the same result as R8.
- R11: The period written by an accepted service sets the window and timeout from that restart onward.
- R12: When `err_clr_en` is high, each `err_mask` bit set to one clears the matching error bit. If an error is set in the same cycle as it is cleared, the set wins.
- R13: The tick count advances only in cycles with `tick` high. With `tick` low no timeout can occur.
- R14: In run mode, a legal write in the same cycle as the tick that would complete the period is accepted, not treated as a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | Time-base enable, one tick per high cycle |
| wr_en | input | 1 | Service write strobe |
| wr_data | input | 9 | {prescaler[1:0], period code[3:0], mode[2:0]} |
| err_clr_en | input | 1 | Error clear strobe |
| err_mask | input | 3 | Error bits to clear (write one to clear) |
| rst_req | output | 1 | One-cycle reset request |
| fail_safe | output | 1 | Fail-safe state, held until power-on reset |
| startup | output | 1 | Start-up supervision active |
| err_flags | output | 3 | Sticky errors: [0] early, [1] late, [2] illegal code |
| mode | output | 3 | Accepted operating mode |

## Verification
Directed sequences put services exactly at the half-period edge, one tick below it, and on the expiring tick. These tell a correct window apart from off-by-one errors in either bound. Long idle runs with the tick high, and with the tick low, separate a real start-up escalation from a timer that ignores the time base. Service writes with each illegal field, in every phase, show that rejection depends on the phase. Each period code is then timed to its timeout, which checks the table and the prescaler. A seeded random mix of ticks, services, illegal codes and clears is compared every cycle against a bench model of the requirements. This exposes wrong interactions between the faults, the clear path and mode changes.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
    localparam int MODE_W     = 3;
    localparam int PCODE_W    = 4;
    localparam int PRE_W      = 2;
    localparam int WR_W       = MODE_W + PCODE_W + PRE_W;
    localparam int NUM_MODES  = 6;
    localparam int NUM_PCODES = 10;
    localparam int NUM_ERR    = 3;
    localparam int BASE_W     = 11;
    localparam int MAX_BASE   = 1024;
    localparam int PRE_STEPS  = 1 << PRE_W;

    localparam int ERR_EARLY = 0;
    localparam int ERR_LATE  = 1;
    localparam int ERR_CODE  = 2;

    localparam logic [MODE_W-1:0] MD_IDLE = 3'd0;
    localparam logic [MODE_W-1:0] MD_RUN  = 3'd1;

    typedef enum logic [1:0] {
        ST_START    = 2'd0,
        ST_WINDOW   = 2'd1,
        ST_TIMEOUT  = 2'd2,
        ST_FAILSAFE = 2'd3
    } wd_state_e;

    typedef struct packed {
        wd_state_e           st;
        logic                strike;
        logic [MODE_W-1:0]   mode;
        logic [PCODE_W-1:0]  pcode;
        logic [PRE_W-1:0]    presc;
        logic                rst_req;
        logic                fail;
    } wd_regs_t;

    function automatic logic [BASE_W-1:0] base_ticks(input logic [PCODE_W-1:0] code);
        logic [BASE_W-1:0] b;
        unique case (code)
            4'd0:    b = 11'd8;
            4'd1:    b = 11'd16;
            4'd2:    b = 11'd32;
            4'd3:    b = 11'd40;
            4'd4:    b = 11'd48;
            4'd5:    b = 11'd64;
            4'd6:    b = 11'd128;
            4'd7:    b = 11'd256;
            4'd8:    b = 11'd512;
            4'd9:    b = 11'd1024;
            default: b = 11'd8;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/wdw_decode.sv
module wdw_decode
    import wdw_pkg::*;
(
    input  logic [WR_W-1:0]    wr_data,
    output logic [MODE_W-1:0]  wr_mode,
    output logic [PCODE_W-1:0] wr_pcode,
    output logic [PRE_W-1:0]   wr_presc,
    output logic               mode_ok,
    output logic               pcode_ok
);
    always_comb begin
        wr_mode  = wr_data[MODE_W-1:0];
        wr_pcode = wr_data[MODE_W +: PCODE_W];
        wr_presc = wr_data[MODE_W+PCODE_W +: PRE_W];
        mode_ok  = (wr_mode  < MODE_W'(NUM_MODES));
        pcode_ok = (wr_pcode < PCODE_W'(NUM_PCODES));
    end
endmodule

// File: rtl/wdw_period.sv
module wdw_period
    import wdw_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic [PCODE_W-1:0] pcode,
    input  logic [PRE_W-1:0]   presc,
    output logic [CNT_W-1:0]   period_len
);
    logic [CNT_W-1:0] base_ext;
    logic [CNT_W-1:0] scaled [PRE_STEPS];

    always_comb base_ext = CNT_W'(base_ticks(pcode));

    for (genvar g = 0; g < PRE_STEPS; g++) begin : g_scale
        assign scaled[g] = base_ext << g;
    end

    always_comb period_len = scaled[presc];
endmodule

// File: rtl/wdw_timer.sv
module wdw_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expire,
    output logic             half_reached
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)   cnt_d = '0;
        else if (tick) cnt_d = cnt_q + CNT_W'(1);
        expire       = tick && (cnt_q == limit - CNT_W'(1));
        half_reached = (cnt_q >= (limit >> 1));
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8
    cnt_below_limit_chk: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q < limit);

    // R13
    idle_tick_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!tick && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/wdw_errs.sv
module wdw_errs #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [N-1:0] set,
    input  logic         clr_en,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (clr_en) flags_d = flags_d & ~clr_mask;
        flags_d = flags_d | set;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R12
        set_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
            set[i] |=> flags_q[i]);
        // R12
        clear_takes_chk: assert property (@(posedge clk) disable iff (!por_n)
            (clr_en && clr_mask[i] && !set[i]) |=> !flags_q[i]);
    end
endmodule

// File: rtl/winwdg.sv
module winwdg
    import wdw_pkg::*;
#(
    parameter int INIT_TICKS = 256
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 tick,
    input  logic                 wr_en,
    input  logic [WR_W-1:0]      wr_data,
    input  logic                 err_clr_en,
    input  logic [NUM_ERR-1:0]   err_mask,
    output logic                 rst_req,
    output logic                 fail_safe,
    output logic                 startup,
    output logic [NUM_ERR-1:0]   err_flags,
    output logic [MODE_W-1:0]    mode
);
    localparam int PER_MAX = MAX_BASE << (PRE_STEPS - 1);
    localparam int LIM_MAX = (INIT_TICKS > PER_MAX) ? INIT_TICKS : PER_MAX;
    localparam int CNT_W   = $clog2(LIM_MAX + 1);

    localparam wd_regs_t REGS_RST = '{
        st: ST_START, strike: 1'b0, mode: MD_IDLE, pcode: '0,
        presc: '0, rst_req: 1'b0, fail: 1'b0
    };

    wd_regs_t cur_q, nxt_d;

    logic [MODE_W-1:0]  wr_mode;
    logic [PCODE_W-1:0] wr_pcode;
    logic [PRE_W-1:0]   wr_presc;
    logic               mode_ok, pcode_ok;
    logic               wr_legal, wr_bad;
    logic [CNT_W-1:0]   period_len, limit;
    logic               expire, half_reached, restart;
    logic [NUM_ERR-1:0] err_set;

    wdw_decode u_decode (
        .wr_data  (wr_data),
        .wr_mode  (wr_mode),
        .wr_pcode (wr_pcode),
        .wr_presc (wr_presc),
        .mode_ok  (mode_ok),
        .pcode_ok (pcode_ok)
    );

    wdw_period #(.CNT_W(CNT_W)) u_period (
        .pcode      (cur_q.pcode),
        .presc      (cur_q.presc),
        .period_len (period_len)
    );

    always_comb limit = (cur_q.st == ST_START) ? CNT_W'(INIT_TICKS) : period_len;

    wdw_timer #(.CNT_W(CNT_W)) u_timer (
        .clk          (clk),
        .por_n        (por_n),
        .tick         (tick),
        .restart      (restart),
        .limit        (limit),
        .expire       (expire),
        .half_reached (half_reached)
    );

    wdw_errs #(.N(NUM_ERR)) u_errs (
        .clk      (clk),
        .por_n    (por_n),
        .set      (err_set),
        .clr_en   (err_clr_en),
        .clr_mask (err_mask),
        .flags    (err_flags)
    );

    always_comb begin
        wr_legal = wr_en && mode_ok && pcode_ok;
        wr_bad   = wr_en && !(mode_ok && pcode_ok);
    end

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.rst_req = 1'b0;
        restart       = 1'b0;
        err_set       = '0;
        unique case (cur_q.st)
            ST_START: begin
                if (wr_legal) begin
                    nxt_d.mode   = wr_mode;
                    nxt_d.pcode  = wr_pcode;
                    nxt_d.presc  = wr_presc;
                    nxt_d.strike = 1'b0;
                    nxt_d.st     = (wr_mode == MD_RUN) ? ST_WINDOW : ST_TIMEOUT;
                    restart      = 1'b1;
                end else begin
                    if (wr_bad) err_set[ERR_CODE] = 1'b1;
                    if (expire) begin
                        restart = 1'b1;
                        if (cur_q.strike) begin
                            nxt_d.st   = ST_FAILSAFE;
                            nxt_d.fail = 1'b1;
                            nxt_d.mode = MD_IDLE;
                        end else begin
                            nxt_d.strike  = 1'b1;
                            nxt_d.rst_req = 1'b1;
                        end
                    end
                end
            end
            ST_WINDOW: begin
                if (wr_legal && half_reached) begin
                    nxt_d.mode  = wr_mode;
                    nxt_d.pcode = wr_pcode;
                    nxt_d.presc = wr_presc;
                    nxt_d.st    = (wr_mode == MD_RUN) ? ST_WINDOW : ST_TIMEOUT;
                    restart     = 1'b1;
                end else if (wr_legal || wr_bad || expire) begin
                    if (wr_legal)    err_set[ERR_EARLY] = 1'b1;
                    else if (wr_bad) err_set[ERR_CODE]  = 1'b1;
                    else             err_set[ERR_LATE]  = 1'b1;
                    nxt_d.rst_req = 1'b1;
                    nxt_d.st      = ST_START;
                    nxt_d.strike  = 1'b0;
                    nxt_d.mode    = MD_IDLE;
                    restart       = 1'b1;
                end
            end
            ST_TIMEOUT: begin
                if (wr_legal) begin
                    nxt_d.mode  = wr_mode;
                    nxt_d.pcode = wr_pcode;
                    nxt_d.presc = wr_presc;
                    nxt_d.st    = (wr_mode == MD_RUN) ? ST_WINDOW : ST_TIMEOUT;
                    restart     = 1'b1;
                end else begin
                    if (wr_bad) err_set[ERR_CODE] = 1'b1;
                    if (expire) begin
                        err_set[ERR_LATE] = 1'b1;
                        nxt_d.rst_req     = 1'b1;
                        nxt_d.st          = ST_START;
                        nxt_d.strike      = 1'b0;
                        nxt_d.mode        = MD_IDLE;
                        restart           = 1'b1;
                    end
                end
            end
            ST_FAILSAFE: begin
                restart = 1'b1;
            end
            default: begin
                nxt_d = REGS_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cur_q <= REGS_RST;
        else        cur_q <= nxt_d;
    end

    assign rst_req   = cur_q.rst_req;
    assign fail_safe = cur_q.fail;
    assign startup   = (cur_q.st == ST_START);
    assign mode      = cur_q.mode;

    // R3
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);

    // R3
    rst_restarts_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> startup);

    // R4
    fail_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        fail_safe |=> fail_safe);

    // R4
    fail_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        fail_safe |-> (!rst_req && !startup && mode == MD_IDLE));

    // R7
    early_resets_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(err_flags[ERR_EARLY]) |-> (rst_req && startup));

    // R2
    mode_legal_chk: assert property (@(posedge clk) disable iff (!por_n)
        mode < MODE_W'(NUM_MODES));
endmodule

// File: tb/winwdg_bench.sv
module winwdg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int INIT = 32;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       err_clr_en = 1'b0;
    logic [2:0] err_mask = '0;
    logic       rst_req, fail_safe, startup;
    logic [2:0] err_flags, mode;

    winwdg #(.INIT_TICKS(INIT)) u_winwdg (
        .clk(clk), .por_n(por_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .err_clr_en(err_clr_en), .err_mask(err_mask), .rst_req(rst_req),
        .fail_safe(fail_safe), .startup(startup), .err_flags(err_flags), .mode(mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R1";

    // model state: st 0 start, 1 window, 2 timeout-only, 3 fail-safe
    int       m_st, m_cnt, m_mode, m_pc, m_ps;
    bit       m_strike, m_rr, m_fs;
    bit [2:0] m_err;

    function automatic int exp_len(input int c, input int p);
        int b;
        case (c)
            0: b = 8;    1: b = 16;   2: b = 32;  3: b = 40;  4: b = 48;
            5: b = 64;   6: b = 128;  7: b = 256; 8: b = 512; 9: b = 1024;
            default: b = 0;
        endcase
        return b * (1 << p);
    endfunction

    function automatic logic [8:0] mk(input int m, input int pc, input int ps);
        return {2'(ps), 4'(pc), 3'(m)};
    endfunction

    task automatic check(input string tg, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tg, act, expv, $time);
        end
    endtask

    task automatic go_start(inout bit [2:0] set, input int bit_i, inout bit rs);
        set[bit_i] = 1'b1;
        m_rr = 1'b1; m_st = 0; m_strike = 1'b0; m_mode = 0; rs = 1'b1;
    endtask

    task automatic model_step(input bit por, input bit t, input bit we, input logic [8:0] wd,
                              input bit ce, input logic [2:0] cm);
        int lim, wm, wp, ws;
        bit ok, bad, ex, half, rs;
        bit [2:0] set;
        if (!por) begin
            m_st = 0; m_cnt = 0; m_mode = 0; m_pc = 0; m_ps = 0;
            m_strike = 0; m_rr = 0; m_fs = 0; m_err = 0;
            return;
        end
        wm = int'(wd[2:0]); wp = int'(wd[6:3]); ws = int'(wd[8:7]);
        ok  = we && wm < 6 && wp < 10;
        bad = we && !ok;
        lim = (m_st == 0) ? INIT : exp_len(m_pc, m_ps);
        ex   = t && (m_cnt == lim - 1);
        half = (m_cnt >= lim / 2);
        set = 0; m_rr = 0; rs = 0;
        case (m_st)
            0: begin
                if (ok) begin
                    m_mode = wm; m_pc = wp; m_ps = ws; m_strike = 0; rs = 1;
                    m_st = (wm == 1) ? 1 : 2;
                end else begin
                    if (bad) set[2] = 1;
                    if (ex) begin
                        rs = 1;
                        if (m_strike) begin m_st = 3; m_fs = 1; m_mode = 0; end
                        else begin m_strike = 1; m_rr = 1; end
                    end
                end
            end
            1: begin
                if (ok && half) begin
                    m_mode = wm; m_pc = wp; m_ps = ws; rs = 1;
                    m_st = (wm == 1) ? 1 : 2;
                end else if (ok)  go_start(set, 0, rs);
                else if (bad)     go_start(set, 2, rs);
                else if (ex)      go_start(set, 1, rs);
            end
            2: begin
                if (ok) begin
                    m_mode = wm; m_pc = wp; m_ps = ws; rs = 1;
                    m_st = (wm == 1) ? 1 : 2;
                end else begin
                    if (bad) set[2] = 1;
                    if (ex) go_start(set, 1, rs);
                end
            end
            default: rs = 1;
        endcase
        if (rs) m_cnt = 0;
        else if (t) m_cnt = m_cnt + 1;
        if (ce) m_err = m_err & ~cm;
        m_err = m_err | set;
    endtask

    task automatic cyc(input bit t, input bit we, input logic [8:0] wd,
                       input bit ce, input logic [2:0] cm);
        int got, want;
        tick = t; wr_en = we; wr_data = wd; err_clr_en = ce; err_mask = cm;
        @(posedge clk);
        @(negedge clk);
        model_step(por_n, t, we, wd, ce, cm);
        got  = int'({rst_req, fail_safe, startup, err_flags, mode});
        want = int'({m_rr, m_fs, (m_st == 0), m_err, 3'(m_mode)});
        check(tag, got, want);
    endtask

    task automatic idle(input int n, input bit t);
        for (int i = 0; i < n; i++) cyc(t, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic do_por();
        por_n = 1'b0;
        idle(1, 1'b0);
        por_n = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7319));
        // R1 reset state
        tag = "R1";
        do_por();
        check("R1 startup after reset", int'(startup), 1);
        idle(1, 1'b0);
        check("R1 no reset request", int'(rst_req), 0);

        // R3 first start-up miss
        tag = "R3";
        do_por();
        idle(INIT - 1, 1'b1);
        check("R3 no request before limit", int'(rst_req), 0);
        idle(1, 1'b1);
        check("R3 request at limit", int'(rst_req), 1);
        check("R3 start-up restarted", int'(startup), 1);

        // R4 second miss escalates
        tag = "R4";
        idle(INIT, 1'b1);
        check("R4 fail-safe entered", int'(fail_safe), 1);
        cyc(1'b1, 1'b1, mk(1, 0, 0), 1'b0, '0);
        check("R4 write ignored in fail-safe", int'({startup, mode}), 0);
        idle(40, 1'b1);
        check("R4 fail-safe held", int'(fail_safe), 1);

        // R2 start-up acceptance
        tag = "R2";
        do_por();
        idle(2, 1'b1);
        cyc(1'b1, 1'b1, mk(1, 0, 0), 1'b0, '0);
        check("R2 run mode loaded", int'({startup, mode}), 1);

        // R6 write exactly at half of an 8-tick period
        tag = "R6";
        idle(4, 1'b1);
        cyc(1'b1, 1'b1, mk(1, 1, 0), 1'b0, '0);
        check("R6 window write accepted", int'({rst_req, startup}), 0);

        // R11 new 16-tick period: 6 ticks is now early; R7
        tag = "R11 R7";
        idle(6, 1'b1);
        cyc(1'b1, 1'b1, mk(1, 1, 0), 1'b0, '0);
        check("R7 early fault request", int'(rst_req), 1);
        check("R7 early flag", int'(err_flags), 3'b001);
        check("R11 period applied", int'(startup), 1);

        // R8 late fault
        tag = "R8";
        cyc(1'b1, 1'b1, mk(1, 0, 0), 1'b0, '0);
        idle(7, 1'b1);
        check("R8 no fault before end", int'(rst_req), 0);
        idle(1, 1'b1);
        check("R8 late request", int'(rst_req), 1);
        check("R8 late flag", int'(err_flags), 3'b011);

        // R12 write-one-to-clear
        tag = "R12";
        cyc(1'b0, 1'b0, '0, 1'b1, 3'b011);
        check("R12 cleared", int'(err_flags), 0);

        // R10 timeout-only mode accepts early writes
        tag = "R10";
        cyc(1'b1, 1'b1, mk(2, 0, 0), 1'b0, '0);
        cyc(1'b1, 1'b1, mk(2, 0, 0), 1'b0, '0);
        check("R10 early write accepted", int'({rst_req, startup, mode}), 2);

        // R9 illegal codes
        tag = "R9";
        cyc(1'b1, 1'b1, mk(7, 0, 0), 1'b0, '0);
        check("R9 illegal mode flagged", int'({rst_req, err_flags, mode}), 'b0_100_010);
        cyc(1'b1, 1'b1, mk(2, 11, 0), 1'b0, '0);
        check("R9 illegal period ignored", int'(mode), 2);
        cyc(1'b1, 1'b1, mk(1, 0, 0), 1'b0, '0);
        idle(5, 1'b1);
        cyc(1'b1, 1'b1, mk(1, 12, 0), 1'b0, '0);
        check("R9 illegal in run resets", int'({rst_req, startup}), 3);

        // R12 set beats clear
        tag = "R12";
        cyc(1'b1, 1'b1, mk(6, 0, 0), 1'b1, 3'b100);
        check("R12 set wins", int'(err_flags[2]), 1);
        cyc(1'b1, 1'b0, '0, 1'b1, 3'b100);
        check("R12 clear alone", int'(err_flags[2]), 0);

        // R13 no ticks, no timeout
        tag = "R13";
        cyc(1'b1, 1'b1, mk(1, 0, 0), 1'b0, '0);
        idle(50, 1'b0);
        check("R13 still running", int'({rst_req, startup}), 0);
        idle(4, 1'b1);
        cyc(1'b0, 1'b1, mk(1, 0, 0), 1'b0, '0);
        check("R13 window after ticks", int'(rst_req), 0);

        // R14 write on the expiring tick
        tag = "R14";
        idle(7, 1'b1);
        cyc(1'b1, 1'b1, mk(1, 0, 0), 1'b0, '0);
        check("R14 write wins over timeout", int'({rst_req, startup}), 0);

        // R5 period table and prescaler
        tag = "R5";
        do_por();
        for (int k = 0; k < 13; k++) begin
            int c, p, n;
            c = (k < 10) ? k : 2;
            p = (k < 10) ? 0 : k - 9;
            cyc(1'b1, 1'b1, mk(2, c, p), 1'b0, '0);
            n = 0;
            do begin
                idle(1, 1'b1);
                n++;
            end while (!rst_req && n < 9000);
            check("R5 period length", n, exp_len(c, p));
        end

        // random mix
        tag = "R6 R7 R8 R9 R10 R12 random";
        for (int i = 0; i < 20000; i++) begin
            bit t, we, ce;
            int m, pc, ps;
            logic [2:0] cm;
            if (m_fs || ($urandom % 4000) == 0) do_por();
            t  = ($urandom % 4) != 0;
            we = ($urandom % 6) == 0;
            ce = ($urandom % 20) == 0;
            cm = 3'($urandom);
            case ($urandom % 8)
                0: m = 0; 1: m = 2; 2: m = 3; 3: m = 4; 4: m = 5;
                default: m = 1;
            endcase
            if (($urandom % 12) == 0) m = 6 + int'($urandom % 2);
            pc = int'($urandom % 4);
            if (($urandom % 16) == 0) pc = 10 + int'($urandom % 6);
            ps = int'($urandom % 2);
            cyc(t, we, mk(m, pc, ps), ce, cm);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule